// File: doc/BRIEF.md
# Ping-Pong DMA Channel Address Engine

This block is the address side of one DMA channel that holds two buffer descriptors, slot A and slot B, and switches between them on its own. Each slot has a current-address register and an end word. Software loads a slot by writing its current address and then its end word. The channel serves a peripheral that raises a request line. For each request it acknowledges the peripheral, presents the active slot's current address on the memory port with a one-cycle strobe, and steps the address by the transfer size. When the active slot reaches its end address, the channel moves to the other slot with no idle cycle in between.

The end word has two flag bits at the top. The other bits give the address of the last transfer in the chunk. When both flags are set on a completing slot, the sequence ends and the channel halts. An interrupt line stays high while the channel is enabled and a slot is empty. The status register shows the pending interrupt, an overflow condition, and a bit that tells software which slot to refill next. With these, software can keep the channel fed without a gap. Data movement, bus arbitration and the memory itself are outside this block.

Top module: `pp_dma_channel`

## Requirements
- R1: After reset, or after a control write with the clear bit (bit 6) set, the channel is disabled. Both slots are empty, overflow is 0, and slot A is next to load, so the status reads 3'b100 while disabled. A clear write also zeroes enable, direction and size.
- R2: The register offsets on reg_addr are 0 current A, 1 end A, 2 current B, 3 end B, 4 control, 5 status. A read returns the selected register one cycle after reg_addr is presented. Control fields: bits [1:0] size code, bit 4 direction (1 means device-to-memory, shown on mem_wr), bit 7 enable. Status fields: bit 0 interrupt pending, bit 1 overflow, bit 2 slot selector.
- R3: Consider a cycle in which dreq is high, the channel is enabled and not halted, and the active slot is loaded. In the next cycle dack and mem_strobe are high, and mem_addr carries the low ADDR_W-2 bits of the active current address. The current address then advances by 1 << size, including after the slot's last transfer.
- R4: A slot completes on the transfer whose address equals its end word with the two top bits masked. The channel then makes the other slot active, and a loaded other slot is served on the very next cycle.
- R5: Writing a slot's end word loads that slot. Writing only its current address leaves the slot empty, and an empty slot's current address does not change.
- R6: irq is high exactly while the channel is enabled, not halted, and at least one slot is empty. It falls in the cycle after the last empty slot's end word is written.
- R7: When a slot completes while the other slot is empty, overflow is set and no transfers take place until the other slot is loaded. Any end-word write clears overflow, unless the channel is halted.
- R8: If a completing slot's end word has both bit ADDR_W-1 (end of sequence) and bit ADDR_W-2 (last transfer) set, the channel halts. Overflow is set, irq drops, and later requests get no acknowledge until a clear write.
- R9: An end word with only bit ADDR_W-1 set does not change sequencing. The channel continues into the other slot.
- R10: The status slot selector is overflow XOR (slot A is next). Software reloads A when the selector and overflow differ, and B when they are equal. The next slot to load is the one opposite the slot most recently loaded.
- R11: A control write with enable 0 stops all transfers and drops irq, and the loaded slots keep their contents. Re-enabling resumes at the stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Registered read data |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Peripheral acknowledge, one cycle per transfer |
| mem_strobe | output | 1 | Memory access strobe |
| mem_addr | output | ADDR_W-2 | Memory byte address |
| mem_wr | output | 1 | 1 = write to memory (device-to-memory) |
| irq | output | 1 | A slot is free to reload |

## Verification
The bench builds the block with ADDR_W = 16. This puts the end-of-sequence and last-transfer flags at bits 15 and 14 above a 14-bit address field, so flagged end words such as 16'hC400 can be written directly. Transfers run with size code 2 (step 4) and size code 0 (step 1), which tests the shifted step and completion on both coarse and fine strides. The scenarios cover a continuous hand-off from slot A to slot B, underrun and reload, the halting end word, an end word with the sequence flag alone, and disable followed by resume. Together they move the status selector through all four overflow/selector combinations.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  typedef enum logic [2:0] {
    RG_CUR_A = 3'd0,
    RG_END_A = 3'd1,
    RG_CUR_B = 3'd2,
    RG_END_B = 3'd3,
    RG_CTRL  = 3'd4,
    RG_STAT  = 3'd5
  } pp_reg_e;

  localparam int CB_DIR = 4;
  localparam int CB_CLR = 6;
  localparam int CB_EN  = 7;
endpackage

// File: rtl/pp_slot.sv
module pp_slot #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_cur,
  input  logic              wr_end,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              adv,
  input  logic [ADDR_W-3:0] step,
  output logic [ADDR_W-1:0] cur_o,
  output logic [ADDR_W-1:0] end_o,
  output logic              valid_o,
  output logic              last_o
);
  localparam int LA = ADDR_W - 2;

  logic [ADDR_W-1:0] cur_q, end_q;
  logic              valid_q;

  assign last_o  = (cur_q[LA-1:0] == end_q[LA-1:0]);
  assign cur_o   = cur_q;
  assign end_o   = end_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      end_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (wr_cur)
        cur_q <= wdata;
      else if (adv)
        cur_q <= {cur_q[ADDR_W-1:LA], cur_q[LA-1:0] + step};
      if (clr)
        valid_q <= 1'b0;
      else if (wr_end) begin
        end_q   <= wdata;
        valid_q <= 1'b1;
      end else if (adv && last_o)
        valid_q <= 1'b0;
    end
  end

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && !wr_cur) |=> $stable(cur_q)); // R5
  AST_END_COMMITS: assert property (@(posedge clk) disable iff (rst)
    (wr_end && !clr) |=> valid_q); // R5
endmodule

// File: rtl/pp_seq.sv
module pp_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       dreq,
  input  logic [1:0] v,
  input  logic [1:0] lst,
  input  logic [1:0] halt_flag,
  input  logic [1:0] wr_end,
  output logic       act,
  output logic [1:0] adv,
  output logic       go,
  output logic       stop,
  output logic       ovf,
  output logic       nxt,
  output logic       dack
);
  logic oth, done;

  assign oth  = ~act;
  assign go   = en & ~stop & v[act] & dreq;
  assign done = go & lst[act];
  assign adv  = go ? (act ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      act  <= 1'b0;
      stop <= 1'b0;
      ovf  <= 1'b0;
      nxt  <= 1'b0;
      dack <= 1'b0;
    end else begin
      dack <= go;
      if (|wr_end) begin
        nxt <= wr_end[0];
        if (!stop) ovf <= 1'b0;
      end
      if (done) begin
        act <= oth;
        if (halt_flag[act]) begin
          stop <= 1'b1;
          ovf  <= 1'b1;
        end else if (!v[oth] && !wr_end[oth]) begin
          ovf <= 1'b1;
        end
      end
    end
  end

  AST_DACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    dack |-> ($past(dreq) && $past(en))); // R3
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    stop |=> !dack); // R8
  AST_UNDERRUN_OVF: assert property (@(posedge clk) disable iff (rst)
    (done && !clr && !v[oth] && !wr_end[oth]) |=> ovf); // R7
endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              dreq,
  output logic              dack,
  output logic              mem_strobe,
  output logic [ADDR_W-3:0] mem_addr,
  output logic              mem_wr,
  output logic              irq
);
  localparam int LA = ADDR_W - 2;

  logic       en_q, dir_q;
  logic [1:0] size_q;
  logic       ctrl_wr, clr;
  logic [LA-1:0] step;

  logic [1:0][ADDR_W-1:0] cur_s, end_s;
  logic [1:0] v, lst, halt_flag, wr_cur, wr_end, adv;
  logic act, go, stop, ovf, nxt, dack_q;
  logic [2:0] stat;

  assign ctrl_wr = reg_we && (reg_addr == RG_CTRL);
  assign clr     = ctrl_wr && reg_wdata[CB_CLR];
  assign step    = {{(LA-1){1'b0}}, 1'b1} << size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      size_q <= 2'd0;
    end else if (ctrl_wr) begin
      if (reg_wdata[CB_CLR]) begin
        en_q   <= 1'b0;
        dir_q  <= 1'b0;
        size_q <= 2'd0;
      end else begin
        en_q   <= reg_wdata[CB_EN];
        dir_q  <= reg_wdata[CB_DIR];
        size_q <= reg_wdata[1:0];
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_slot
    assign wr_cur[g]    = reg_we && (reg_addr == 3'(2*g));
    assign wr_end[g]    = reg_we && (reg_addr == 3'(2*g+1));
    assign halt_flag[g] = end_s[g][ADDR_W-1] & end_s[g][ADDR_W-2];
    pp_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk(clk), .rst(rst), .clr(clr),
      .wr_cur(wr_cur[g]), .wr_end(wr_end[g]), .wdata(reg_wdata),
      .adv(adv[g]), .step(step),
      .cur_o(cur_s[g]), .end_o(end_s[g]), .valid_o(v[g]), .last_o(lst[g])
    );
  end

  pp_seq u_seq (
    .clk(clk), .rst(rst), .clr(clr), .en(en_q), .dreq(dreq),
    .v(v), .lst(lst), .halt_flag(halt_flag), .wr_end(wr_end),
    .act(act), .adv(adv), .go(go), .stop(stop), .ovf(ovf), .nxt(nxt),
    .dack(dack_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_wr   <= 1'b0;
    end else if (go) begin
      mem_addr <= cur_s[act][LA-1:0];
      mem_wr   <= dir_q;
    end
  end

  assign dack       = dack_q;
  assign mem_strobe = dack_q;
  assign irq        = en_q & ~stop & ~(&v);
  assign stat       = {ovf ^ ~nxt, ovf, irq};

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RG_CUR_A: reg_rdata <= cur_s[0];
        RG_END_A: reg_rdata <= end_s[0];
        RG_CUR_B: reg_rdata <= cur_s[1];
        RG_END_B: reg_rdata <= end_s[1];
        RG_CTRL:  reg_rdata <= ADDR_W'({en_q, 2'b00, dir_q, 2'b00, size_q});
        RG_STAT:  reg_rdata <= ADDR_W'(stat);
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/tb_pp_dma_channel.sv
module tb_pp_dma_channel;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic dreq = 1'b0;
  logic dack, mem_strobe, mem_wr, irq;
  logic [AW-3:0] mem_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pp_dma_channel #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
    .mem_strobe(mem_strobe), .mem_addr(mem_addr), .mem_wr(mem_wr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [AW-1:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic xfer(input string req, input int n, input logic [AW-3:0] a0,
                      input logic [AW-3:0] stp, input logic wdir);
    dreq = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) dreq = 1'b0;
      chk({req, " dack"}, dack, 1);
      chk({req, " strobe"}, mem_strobe, 1);
      chk({req, " addr"}, mem_addr, a0 + stp * i);
      chk({req, " dir"}, mem_wr, wdir);
    end
  endtask

  task automatic xfer_seq(input string req, input logic [AW-3:0] a [6], input int n);
    dreq = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) dreq = 1'b0;
      chk({req, " dack"}, dack, 1);
      chk({req, " addr"}, mem_addr, a[i]);
    end
  endtask

  task automatic no_xfer(input string req, input int n);
    dreq = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({req, " no dack"}, dack, 0);
    end
    dreq = 1'b0;
  endtask

  task automatic t_reset;
    logic [AW-1:0] d;
    chk("R1 dack after reset", dack, 0);
    chk("R1 irq after reset", irq, 0);
    rd(3'd5, d);
    chk("R1 status after reset", d, 16'h0004);
  endtask

  task automatic t_load;
    logic [AW-1:0] d;
    wr(3'd4, 16'h0040);
    wr(3'd4, 16'h0092);
    rd(3'd5, d);
    chk("R6 status both empty", d, 16'h0005);
    wr(3'd0, 16'h0100);
    wr(3'd1, 16'h010C);
    rd(3'd5, d);
    chk("R10 status after A load", d, 16'h0001);
    wr(3'd2, 16'h0200);
    chk("R5 current write alone keeps irq", irq, 1);
    wr(3'd3, 16'h0204);
    chk("R6 irq falls after B end write", irq, 0);
    rd(3'd5, d);
    chk("R10 status both loaded", d, 16'h0004);
    rd(3'd4, d);
    chk("R2 control readback", d, 16'h0092);
  endtask

  task automatic t_pingpong;
    logic [AW-1:0] d;
    logic [AW-3:0] a [6];
    a = '{14'h100, 14'h104, 14'h108, 14'h10C, 14'h200, 14'h204};
    xfer_seq("R4 A to B no gap", a, 6);
    chk("R3 write direction", mem_wr, 1);
    rd(3'd5, d);
    chk("R7 R10 status after underrun", d, 16'h0003);
    no_xfer("R7 empty active slot", 3);
  endtask

  task automatic t_reload;
    logic [AW-1:0] d;
    wr(3'd0, 16'h0300);
    wr(3'd1, 16'h0304);
    rd(3'd5, d);
    chk("R7 overflow cleared by load", d, 16'h0001);
    xfer("R3 resume after reload", 2, 14'h300, 14'd4, 1'b1);
    rd(3'd5, d);
    chk("R10 status ovf and B next", d, 16'h0007);
  endtask

  task automatic t_halt;
    logic [AW-1:0] d;
    wr(3'd2, 16'h0400);
    wr(3'd3, 16'hC400);
    xfer("R8 final transfer", 1, 14'h400, 14'd4, 1'b1);
    chk("R8 irq low when halted", irq, 0);
    rd(3'd5, d);
    chk("R8 status halted", d, 16'h0002);
    no_xfer("R8 halted", 3);
  endtask

  task automatic t_seq_only;
    logic [AW-1:0] d;
    logic [AW-3:0] a [6];
    wr(3'd4, 16'h0040);
    rd(3'd5, d);
    chk("R1 status after clear", d, 16'h0004);
    wr(3'd4, 16'h0082);
    wr(3'd0, 16'h0500);
    wr(3'd1, 16'h8504);
    wr(3'd2, 16'h0600);
    wr(3'd3, 16'h0600);
    a = '{14'h500, 14'h504, 14'h600, 14'h0, 14'h0, 14'h0};
    xfer_seq("R9 sequence flag alone", a, 3);
    chk("R11 read direction", mem_wr, 0);
    rd(3'd1, d);
    chk("R2 end A readback", d, 16'h8504);
    rd(3'd0, d);
    chk("R3 address advanced past end", d, 16'h0508);
  endtask

  task automatic t_disable;
    wr(3'd0, 16'h0700);
    wr(3'd1, 16'h0702);
    wr(3'd4, 16'h0000);
    chk("R11 irq low when disabled", irq, 0);
    no_xfer("R11 disabled", 3);
    wr(3'd4, 16'h0080);
    xfer("R11 R3 resume step 1", 3, 14'h700, 14'd1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_load;
    t_pingpong;
    t_reload;
    t_halt;
    t_seq_only;
    t_disable;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule